// File: doc/BRIEF.md
# Two-Level Interrupt Request Gating

This block gathers single-cycle request pulses from two families of sources, general peripherals and DMA channels, into two sticky status registers. Each register has a companion mask. Software clears a status bit by writing a 1 to it and flips a mask bit by writing a 1 to it. Every cycle the block weighs the status and mask contents against a processor status word and a DMA master enable. From that it drives two registered exception request flags, each paired with the vector offset the processor should enter at.

The general path is a plain enable-and-mask gate keyed on a single processor status bit. It also emits a one-cycle strobe, which tells the timer logic to latch the counts of timers 0 and 1. The strobe fires when a general request is raised while general source 1 is pending. When the general path is enabled but nothing at all is pending, a spurious flag is raised instead of a request. The DMA path needs an exact multi-bit processor status pattern and the DMA master enable. It fires on a masked hit, or on the bus-error bit, which is the top status bit, with no mask bit needed.

Top module: `irq_gate_top`

## Requirements
- R1: A pulse on general source n sets `gen_status[n]` at the next clock edge. A pulse on DMA source n sets `dma_status[n]` at the next clock edge. Set bits stay set until acknowledged.
- R2: `gen_exc_req` is 1 exactly when, one edge earlier, `cpu_status[10]` was 1 and `gen_status & gen_mask` was nonzero.
- R3: `timer_capture` is a one-cycle pulse. It is 1 exactly when `gen_exc_req` rises and, one edge earlier, `gen_status[1]` was 1.
- R4: `dma_exc_req` requires that, one edge earlier, `cpu_status & 0x0001_0807` equalled `0x0001_0801`. Bits outside that mask, such as bit 3, do not matter.
- R5: `dma_exc_req` requires that `dma_enable`, which stands for bit 0 of the DMA control register, was 1 one edge earlier.
- R6: With R4 and R5 met, `dma_exc_req` is 1 when, one edge earlier, either `dma_status & dma_mask` was nonzero or `dma_status[15]` (bus error) was 1. Bit 15 needs no mask bit.
- R7: `gen_exc_vec` reads 0x400 while `gen_exc_req` is 1, and `dma_exc_vec` reads 0x800 while `dma_exc_req` is 1. Each vector reads 0 while its request is 0.
- R8: `gen_spurious` is 1 exactly when, one edge earlier, `cpu_status[10]` was 1 and `gen_status` was all zero. No general request is raised in that case.
- R9: A status write with its enable high clears each status bit written as 1. If a source pulse arrives in the same cycle as the write, the pulse wins and the bit stays set.
- R10: A mask write with its enable high inverts each mask bit written as 1 and leaves the others unchanged.
- R11: Both request outputs are re-evaluated every cycle. Each drops at the edge after its condition stops holding.
- R12: After synchronous reset, all status and mask bits and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_src_pulse | input | GEN_W | Per-source general request pulses |
| dma_src_pulse | input | DMA_W | Per-channel DMA request pulses |
| cpu_status | input | 32 | Processor status word |
| dma_enable | input | 1 | Bit 0 of the DMA control register |
| gen_ack_we | input | 1 | General status clear strobe |
| gen_ack_bits | input | GEN_W | General status bits to clear |
| gen_mask_we | input | 1 | General mask toggle strobe |
| gen_mask_bits | input | GEN_W | General mask bits to invert |
| dma_ack_we | input | 1 | DMA status clear strobe |
| dma_ack_bits | input | DMA_W | DMA status bits to clear |
| dma_mask_we | input | 1 | DMA mask toggle strobe |
| dma_mask_bits | input | DMA_W | DMA mask bits to invert |
| gen_exc_req | output | 1 | General exception request |
| gen_exc_vec | output | 12 | General vector offset |
| dma_exc_req | output | 1 | DMA exception request |
| dma_exc_vec | output | 12 | DMA vector offset |
| timer_capture | output | 1 | Timer 0/1 hold strobe |
| gen_spurious | output | 1 | Enabled with nothing pending |
| gen_status | output | GEN_W | General status register |
| gen_mask | output | GEN_W | General mask register |
| dma_status | output | DMA_W | DMA status register |
| dma_mask | output | DMA_W | DMA mask register |

## Verification
The DMA gate is driven with processor words that match the pattern exactly, that also carry a don't-care bit, that carry an extra bit inside the compare mask, and that lack bit 16. This separates a true masked compare from a loose bit test. Bus-error-only pending is set against masked and unmasked channel hits, which shows that bit 15 bypasses the mask. On the general path, pending source 1 is compared with other sources to pin down the capture strobe. An empty status register shows the spurious flag, and a source pulse in the same cycle as its acknowledge shows which one has priority. A long stretch of random pulses, writes and status words is then compared cycle by cycle against a behavioural model.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    localparam int CPU_W = 32;
    localparam int VEC_W = 12;
    localparam int GEN_EN_BIT = 10;
    localparam logic [CPU_W-1:0] DMA_CPU_SEL   = 32'h0001_0807;
    localparam logic [CPU_W-1:0] DMA_CPU_MATCH = 32'h0001_0801;
    localparam logic [VEC_W-1:0] GEN_VEC = 12'h400;
    localparam logic [VEC_W-1:0] DMA_VEC = 12'h800;

    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
    } exc_out_t;

    function automatic logic dma_cpu_ok(input logic [CPU_W-1:0] s);
        return (s & DMA_CPU_SEL) == DMA_CPU_MATCH;
    endfunction

    function automatic exc_out_t make_exc(input logic req, input logic [VEC_W-1:0] v);
        exc_out_t e;
        e.req = req;
        e.vec = req ? v : '0;
        return e;
    endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         ack_we,
    input  logic [W-1:0] ack_bits,
    input  logic         mask_we,
    input  logic [W-1:0] mask_bits,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] clr;
    assign clr = ack_we ? ack_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_o <= '0;
            mask_o <= '0;
        end else begin
            stat_o <= (stat_o & ~clr) | set_i;
            if (mask_we) mask_o <= mask_o ^ mask_bits;
        end
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R1
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ack_we |=> ((stat_o & $past(ack_bits & ~set_i)) == '0)); // R9
endmodule

// File: rtl/irq_gen_eval.sv
module irq_gen_eval
    import irq_gate_pkg::*;
#(
    parameter int GEN_W   = 16,
    parameter int CAP_SRC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_en,
    input  logic [GEN_W-1:0] stat,
    input  logic [GEN_W-1:0] mask,
    output exc_out_t         exc_o,
    output logic             capture_o,
    output logic             spurious_o
);
    logic req_q, any_pend, hit, req_d;

    assign any_pend = |stat;
    assign hit      = |(stat & mask);
    assign req_d    = cpu_en & any_pend & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            capture_o  <= 1'b0;
            spurious_o <= 1'b0;
        end else begin
            req_q      <= req_d;
            capture_o  <= req_d & ~req_q & stat[CAP_SRC];
            spurious_o <= cpu_en & ~any_pend;
        end
    end

    assign exc_o = make_exc(req_q, GEN_VEC);

    AST_GEN_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        exc_o.req |-> $past(cpu_en)); // R2
    AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        capture_o |-> (exc_o.req && !$past(exc_o.req))); // R3
    AST_SPURIOUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        spurious_o |-> !exc_o.req); // R8
    AST_GEN_VECTOR: assert property (@(posedge clk) disable iff (rst)
        exc_o.req |-> (exc_o.vec == GEN_VEC)); // R7
endmodule

// File: rtl/irq_dma_eval.sv
module irq_dma_eval
    import irq_gate_pkg::*;
#(
    parameter int DMA_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CPU_W-1:0] cpu_status,
    input  logic             dma_enable,
    input  logic [DMA_W-1:0] stat,
    input  logic [DMA_W-1:0] mask,
    output exc_out_t         exc_o
);
    localparam int ERR_BIT = DMA_W - 1;

    logic req_q, pend;
    assign pend = (|(stat & mask)) | stat[ERR_BIT];

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= dma_cpu_ok(cpu_status) & dma_enable & pend;
    end

    assign exc_o = make_exc(req_q, DMA_VEC);

    AST_DMA_CPU_PATTERN: assert property (@(posedge clk) disable iff (rst)
        exc_o.req |-> $past((cpu_status & DMA_CPU_SEL) == DMA_CPU_MATCH)); // R4
    AST_DMA_MASTER_EN: assert property (@(posedge clk) disable iff (rst)
        exc_o.req |-> $past(dma_enable)); // R5
endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
    import irq_gate_pkg::*;
#(
    parameter int GEN_W = 16,
    parameter int DMA_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GEN_W-1:0] gen_src_pulse,
    input  logic [DMA_W-1:0] dma_src_pulse,
    input  logic [31:0]      cpu_status,
    input  logic             dma_enable,
    input  logic             gen_ack_we,
    input  logic [GEN_W-1:0] gen_ack_bits,
    input  logic             gen_mask_we,
    input  logic [GEN_W-1:0] gen_mask_bits,
    input  logic             dma_ack_we,
    input  logic [DMA_W-1:0] dma_ack_bits,
    input  logic             dma_mask_we,
    input  logic [DMA_W-1:0] dma_mask_bits,
    output logic             gen_exc_req,
    output logic [11:0]      gen_exc_vec,
    output logic             dma_exc_req,
    output logic [11:0]      dma_exc_vec,
    output logic             timer_capture,
    output logic             gen_spurious,
    output logic [GEN_W-1:0] gen_status,
    output logic [GEN_W-1:0] gen_mask,
    output logic [DMA_W-1:0] dma_status,
    output logic [DMA_W-1:0] dma_mask
);
    exc_out_t gen_exc, dma_exc;

    irq_status_bank #(.W(GEN_W)) u_gen_bank (
        .clk(clk), .rst(rst), .set_i(gen_src_pulse),
        .ack_we(gen_ack_we), .ack_bits(gen_ack_bits),
        .mask_we(gen_mask_we), .mask_bits(gen_mask_bits),
        .stat_o(gen_status), .mask_o(gen_mask));

    irq_status_bank #(.W(DMA_W)) u_dma_bank (
        .clk(clk), .rst(rst), .set_i(dma_src_pulse),
        .ack_we(dma_ack_we), .ack_bits(dma_ack_bits),
        .mask_we(dma_mask_we), .mask_bits(dma_mask_bits),
        .stat_o(dma_status), .mask_o(dma_mask));

    irq_gen_eval #(.GEN_W(GEN_W), .CAP_SRC(1)) u_gen_eval (
        .clk(clk), .rst(rst), .cpu_en(cpu_status[GEN_EN_BIT]),
        .stat(gen_status), .mask(gen_mask), .exc_o(gen_exc),
        .capture_o(timer_capture), .spurious_o(gen_spurious));

    irq_dma_eval #(.DMA_W(DMA_W)) u_dma_eval (
        .clk(clk), .rst(rst), .cpu_status(cpu_status), .dma_enable(dma_enable),
        .stat(dma_status), .mask(dma_mask), .exc_o(dma_exc));

    assign gen_exc_req = gen_exc.req;
    assign gen_exc_vec = gen_exc.vec;
    assign dma_exc_req = dma_exc.req;
    assign dma_exc_vec = dma_exc.vec;

    AST_DMA_VECTOR: assert property (@(posedge clk) disable iff (rst)
        dma_exc_req |-> (dma_exc_vec == 12'h800)); // R7
    AST_DROP_AFTER_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !cpu_status[GEN_EN_BIT] |=> !gen_exc_req); // R11
endmodule

// File: tb/irq_gate_top_test.sv
`timescale 1ns/1ps
module irq_gate_top_test;
    localparam int GW = 16;
    localparam int DW = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic [GW-1:0] gen_src_pulse = '0, gen_ack_bits = '0, gen_mask_bits = '0;
    logic [DW-1:0] dma_src_pulse = '0, dma_ack_bits = '0, dma_mask_bits = '0;
    logic [31:0] cpu_status = '0;
    logic dma_enable = 1'b0, gen_ack_we = 1'b0, gen_mask_we = 1'b0;
    logic dma_ack_we = 1'b0, dma_mask_we = 1'b0;
    logic gen_exc_req, dma_exc_req, timer_capture, gen_spurious;
    logic [11:0] gen_exc_vec, dma_exc_vec;
    logic [GW-1:0] gen_status, gen_mask;
    logic [DW-1:0] dma_status, dma_mask;

    int checks = 0, errors = 0;
    bit done = 0;

    irq_gate_top #(.GEN_W(GW), .DMA_W(DW)) uut (.*);

    always #2 clk = ~clk;

    // behavioural reference
    logic [GW-1:0] m_gs = '0, m_gm = '0;
    logic [DW-1:0] m_ds = '0, m_dm = '0;
    logic m_greq = 0, m_dreq = 0, m_cap = 0, m_spur = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_gs = '0; m_gm = '0; m_ds = '0; m_dm = '0;
            m_greq = 0; m_dreq = 0; m_cap = 0; m_spur = 0;
        end else begin
            bit en, nreq;
            en   = cpu_status[10];
            nreq = en && ((m_gs & m_gm) != 0);
            m_cap  = nreq && !m_greq && m_gs[1];
            m_greq = nreq;
            m_spur = en && (m_gs == 0);
            m_dreq = ((cpu_status & 32'h10807) == 32'h10801) && dma_enable &&
                     (((m_ds & m_dm) != 0) || m_ds[15]);
            if (gen_ack_we)  m_gs = m_gs & ~gen_ack_bits;
            m_gs = m_gs | gen_src_pulse;
            if (gen_mask_we) m_gm = m_gm ^ gen_mask_bits;
            if (dma_ack_we)  m_ds = m_ds & ~dma_ack_bits;
            m_ds = m_ds | dma_src_pulse;
            if (dma_mask_we) m_dm = m_dm ^ dma_mask_bits;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R1 gen_status", gen_status, m_gs);
            chk("R1 dma_status", dma_status, m_ds);
            chk("R10 gen_mask", gen_mask, m_gm);
            chk("R10 dma_mask", dma_mask, m_dm);
            chk("R2 gen_exc_req", gen_exc_req, m_greq);
            chk("R4 dma_exc_req", dma_exc_req, m_dreq);
            chk("R3 timer_capture", timer_capture, m_cap);
            chk("R8 gen_spurious", gen_spurious, m_spur);
            chk("R7 gen_exc_vec", gen_exc_vec, m_greq ? 32'h400 : 32'h0);
            chk("R7 dma_exc_vec", dma_exc_vec, m_dreq ? 32'h800 : 32'h0);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    task automatic step(); @(negedge clk); endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R12 reset gen_status", gen_status, 0);
        chk("R12 reset requests", {gen_exc_req, dma_exc_req, timer_capture, gen_spurious}, 0);
        // spurious: enabled, nothing pending
        cpu_status = 32'h400;
        step(); step();
        chk("R8 spurious flag", gen_spurious, 1);
        // mask bits 1 and 3, then pulse source 1
        gen_mask_we = 1; gen_mask_bits = 16'h000A; step();
        gen_mask_we = 0; gen_mask_bits = 0;
        chk("R10 mask toggled on", gen_mask, 16'h000A);
        gen_src_pulse = 16'h0002; step();
        gen_src_pulse = 0; step();
        chk("R2 request raised", gen_exc_req, 1);
        chk("R3 capture on rise", timer_capture, 1);
        chk("R7 general vector", gen_exc_vec, 32'h400);
        step();
        chk("R3 capture single cycle", timer_capture, 0);
        cpu_status = 32'h0; step();
        chk("R11 drops when disabled", gen_exc_req, 0);
        cpu_status = 32'h400; step();
        chk("R11 returns when enabled", gen_exc_req, 1);
        gen_ack_we = 1; gen_ack_bits = 16'h0002; step();
        gen_ack_we = 0; gen_ack_bits = 0;
        chk("R9 ack clears bit", gen_status, 0);
        step();
        chk("R11 drops after ack", gen_exc_req, 0);
        gen_mask_we = 1; gen_mask_bits = 16'h0002; step();
        gen_mask_we = 0; gen_mask_bits = 0;
        chk("R10 mask bit 1 toggled off", gen_mask, 16'h0008);
        gen_src_pulse = 16'h0020; step();
        gen_src_pulse = 0; step();
        chk("R2 unmasked source no request", gen_exc_req, 0);
        gen_src_pulse = 16'h0020; gen_ack_we = 1; gen_ack_bits = 16'h0020; step();
        gen_src_pulse = 0; gen_ack_we = 0; gen_ack_bits = 0;
        chk("R9 pulse beats ack", gen_status, 16'h0020);
        // DMA path
        cpu_status = 32'h10801; dma_enable = 1;
        dma_src_pulse = 16'h8000; step();
        dma_src_pulse = 0; step();
        chk("R6 bus error without mask", dma_exc_req, 1);
        chk("R7 dma vector", dma_exc_vec, 32'h800);
        cpu_status = 32'h10805; step();
        chk("R4 extra compared bit blocks", dma_exc_req, 0);
        cpu_status = 32'h10809; step();
        chk("R4 dont-care bit passes", dma_exc_req, 1);
        cpu_status = 32'h00801; step();
        chk("R4 bit16 clear blocks", dma_exc_req, 0);
        cpu_status = 32'h10801; dma_enable = 0; step();
        chk("R5 master enable off blocks", dma_exc_req, 0);
        dma_enable = 1;
        dma_ack_we = 1; dma_ack_bits = 16'h8000; step();
        dma_ack_we = 0; dma_ack_bits = 0;
        dma_src_pulse = 16'h0008; step();
        dma_src_pulse = 0; step();
        chk("R6 unmasked channel no request", dma_exc_req, 0);
        dma_mask_we = 1; dma_mask_bits = 16'h0008; step();
        dma_mask_we = 0; dma_mask_bits = 0; step();
        chk("R6 masked channel request", dma_exc_req, 1);
        // random stretch
        for (int i = 0; i < 3000; i++) begin
            int pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0: cpu_status = 32'h10801;
                1: cpu_status = 32'h10C01;
                2: cpu_status = 32'h10805;
                3: cpu_status = 32'h00400;
                4: cpu_status = 32'h10809;
                default: cpu_status = $urandom;
            endcase
            dma_enable    = ($urandom_range(0, 3) != 0);
            gen_src_pulse = ($urandom_range(0, 3) == 0) ? GW'(1 << $urandom_range(0, GW-1)) : '0;
            dma_src_pulse = ($urandom_range(0, 3) == 0) ? DW'(1 << $urandom_range(0, DW-1)) : '0;
            gen_ack_we    = ($urandom_range(0, 4) == 0);
            gen_ack_bits  = GW'($urandom);
            dma_ack_we    = ($urandom_range(0, 4) == 0);
            dma_ack_bits  = DW'($urandom);
            gen_mask_we   = ($urandom_range(0, 7) == 0);
            gen_mask_bits = GW'($urandom);
            dma_mask_we   = ($urandom_range(0, 7) == 0);
            dma_mask_bits = DW'($urandom);
            step();
        end
        gen_src_pulse = 0; dma_src_pulse = 0;
        gen_ack_we = 0; dma_ack_we = 0; gen_mask_we = 0; dma_mask_we = 0;
        step(); step();
        finish_run();
    end
endmodule